// File: doc/BRIEF.md
# Spare-Via Signal Router

This block carries a group of logical signals across a die-to-die boundary made of vertical connections, some of which may be defective. The vias are split into independent sections. Each section has more vias than signals. A per-via pass/fail map, produced earlier by a separate via test, tells the router which vias may be used. No handshake is needed between the dies.

On the sending side, each signal is steered onto a working via. On the receiving side, an identical decode of the same map picks the same vias and puts the signals back in their original order. Both decodes follow one rule: signal i of a section uses the i-th working via of that section, counting from via 0 upward. A section with too few working vias raises an unrepairable flag. The whole path is combinational and has no clock.

The module holds both halves: the sending mux (`sig_tx` to `via_tx`) and the receiving mux (`via_rx` to `sig_rx`). In a stacked system, each die instantiates the block, uses one half and feeds both halves the same map.

Top module: `via_spare_route`

## Requirements
- R1: Sections are independent. The outputs of section s depend only on that section's map bits, signals and received vias. Map bit s*NVIA+v belongs to via v of section s. Signal bit s*NSIG+i is signal i of section s.
- R2: In each section, signal i is driven onto the i-th via whose map bit is 1 (1 = pass), counting from via index 0 upward.
- R3: `unrepairable[s]` is 1 exactly when section s has fewer than NSIG map bits set to 1.
- R4: On the sending side, every failing via, and every working via beyond the NSIG-th working via, is driven to 0.
- R5: Receive output i of a section equals `via_rx` of the i-th working via of that section. The values on failing vias and on unused working vias have no effect on any receive output.
- R6: In an unrepairable section, the receive outputs that have no working via are 0. The signals that do have a working via are still carried.
- R7: All outputs follow the inputs combinationally, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pass_map | input | NSEC*NVIA | Via test result, 1 = via works |
| sig_tx | input | NSEC*NSIG | Logical signals to send |
| via_tx | output | NSEC*NVIA | Values driven onto the vias |
| via_rx | input | NSEC*NVIA | Values received from the vias |
| sig_rx | output | NSEC*NSIG | Restored logical signals |
| unrepairable | output | NSEC | Per-section flag: too few working vias |

## Verification
The hardest situation to reach from the ports is a receive output that must ignore a toggling via. This needs a via that works but carries nothing, or that fails, while it holds a value that differs from the value a loopback would give.

The bench reaches this in several ways. It feeds `via_rx` from its own model of the sent values and injects noise only on vias its model says carry no signal. It also drives fully random received values and uses maps with surplus working vias. Maps with exactly NSIG, fewer than NSIG, and no working vias cover the flag edge and the zero fill.

// File: rtl/via_spare_route.sv
module via_spare_route #(
  parameter int NSIG = 3,
  parameter int NVIA = 5,
  parameter int NSEC = 2
) (
  input  logic [NSEC*NVIA-1:0] pass_map,
  input  logic [NSEC*NSIG-1:0] sig_tx,
  output logic [NSEC*NVIA-1:0] via_tx,
  input  logic [NSEC*NVIA-1:0] via_rx,
  output logic [NSEC*NSIG-1:0] sig_rx,
  output logic [NSEC-1:0]      unrepairable
);

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic [NVIA-1:0] ok, vt, vr;
    logic [NSIG-1:0] st, sr;
    logic            bad;

    assign ok = pass_map[s*NVIA +: NVIA];
    assign st = sig_tx[s*NSIG +: NSIG];
    assign vr = via_rx[s*NVIA +: NVIA];

    always_comb begin
      int k;
      k  = 0;
      vt = '0;
      sr = '0;
      for (int v = 0; v < NVIA; v++) begin
        if (ok[v] && k < NSIG) begin
          vt[v] = st[k];
          sr[k] = vr[v];
          k = k + 1;
        end
      end
      bad = (k < NSIG);

      // R3
      a_r3_flag_matches_count: assert (bad == ($countones(ok) < NSIG));
      // R4
      for (int v = 0; v < NVIA; v++)
        if (!ok[v]) a_r4_failed_via_low: assert (vt[v] == 1'b0);
      // R6
      for (int i = 0; i < NSIG; i++)
        if (i >= $countones(ok)) a_r6_unassigned_zero: assert (sr[i] == 1'b0);
      // R5: loopback of a repairable section restores the signals
      if (!bad && vr == vt) a_r5_loopback_restores: assert (sr == st);
    end

    assign via_tx[s*NVIA +: NVIA] = vt;
    assign sig_rx[s*NSIG +: NSIG] = sr;
    assign unrepairable[s]        = bad;
  end

endmodule

// File: tb/via_spare_route_tb.sv
`timescale 1ns/1ps
module via_spare_route_tb;
  localparam int NS = 3, NV = 5, NX = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [NX*NV-1:0] map = '0, vrx = '0, vtx;
  logic [NX*NS-1:0] stx = '0, srx;
  logic [NX-1:0]    flag;
  int checks = 0, failures = 0;

  via_spare_route #(.NSIG(NS), .NVIA(NV), .NSEC(NX)) u_dut (
    .pass_map(map), .sig_tx(stx), .via_tx(vtx),
    .via_rx(vrx), .sig_rx(srx), .unrepairable(flag));

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [NX*NV-1:0] etx, evr;
  logic [NX*NS-1:0] erx;
  logic [NX-1:0]    ef;

  // mode 0: loopback, 1: loopback plus noise on non-carrying vias, 2: raw noise
  task automatic model(input logic [NX*NV-1:0] m, input logic [NX*NS-1:0] sg,
                       input int mode, input logic [NX*NV-1:0] noise);
    etx = '0; evr = '0; erx = '0; ef = '0;
    for (int x = 0; x < NX; x++) begin
      int q[$];
      logic [NV-1:0] carry;
      carry = '0;
      for (int v = 0; v < NV; v++) if (m[x*NV+v]) q.push_back(v);
      ef[x] = (q.size() < NS);
      for (int i = 0; i < NS; i++)
        if (i < q.size()) begin
          etx[x*NV+q[i]] = sg[x*NS+i];
          carry[q[i]] = 1'b1;
        end
      for (int v = 0; v < NV; v++)
        case (mode)
          0: evr[x*NV+v] = etx[x*NV+v];
          1: evr[x*NV+v] = carry[v] ? etx[x*NV+v] : noise[x*NV+v];
          default: evr[x*NV+v] = noise[x*NV+v];
        endcase
      for (int i = 0; i < NS; i++)
        if (i < q.size()) erx[x*NS+i] = evr[x*NV+q[i]];
    end
  endtask

  task automatic apply(input logic [NX*NV-1:0] m, input logic [NX*NS-1:0] sg,
                       input int mode, input logic [NX*NV-1:0] noise);
    model(m, sg, mode, noise);
    @(posedge clk); #1;
    map = m; stx = sg; vrx = evr;
    @(negedge clk);
    chk(vtx == etx, "R2 R4 via_tx", 32'(vtx), 32'(etx));
    chk(srx == erx, "R5 sig_rx", 32'(srx), 32'(erx));
    chk(flag == ef, "R3 unrepairable", 32'(flag), 32'(ef));
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NV-1:0] keep_tx;
    logic [NS-1:0] keep_rx;
    #1;
    chk(vtx == '0 && srx == '0, "R7 idle outputs", 32'({vtx, srx}), 32'h0);
    chk(flag == 2'b11, "R3 idle flag", 32'(flag), 32'h3);

    apply({5'b11111, 5'b11111}, 6'b101_110, 0, '0);
    apply({5'b11100, 5'b00111}, 6'b111_111, 1, '1);
    apply({5'b10101, 5'b11010}, 6'b011_101, 1, 10'h2AA);
    apply({5'b01100, 5'b00011}, 6'b111_011, 2, '1);
    apply({5'b00000, 5'b10000}, 6'b111_111, 2, '1);
    chk(srx[5:0] == 6'b000_001, "R6 zero fill", 32'(srx), 32'h1);

    apply({5'b11011, 5'b10111}, 6'b010_101, 1, 10'h155);
    keep_tx = vtx[NV +: NV]; keep_rx = srx[NS +: NS];
    apply({5'b11011, 5'b01001}, 6'b010_000, 1, 10'h155);
    chk(vtx[NV +: NV] == keep_tx, "R1 section 1 via_tx", 32'(vtx[NV +: NV]), 32'(keep_tx));
    chk(srx[NS +: NS] == keep_rx, "R1 section 1 sig_rx", 32'(srx[NS +: NS]), 32'(keep_rx));

    model({5'b11111, 5'b01110}, 6'b110_101, 0, '0);
    @(negedge clk);
    map = {5'b11111, 5'b01110}; stx = 6'b110_101; vrx = evr;
    #0.5;
    chk(vtx == etx && srx == erx, "R7 no-clock response", 32'({vtx, srx}), 32'({etx, erx}));

    for (int n = 0; n < 400; n++) begin
      logic [NX*NV-1:0] m;
      m = (n % 3 == 0) ? 10'($urandom) : 10'($urandom | $urandom);
      apply(m, 6'($urandom), n % 3, 10'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule